// File: doc/BRIEF.md
# Cache-Line Coherence State Controller

This block keeps the coherence state of a small direct-mapped set of cache lines that belong to one caching agent. Each line carries three attributes (valid, unique, dirty), which together give five legal states: Invalid, Shared Clean, Shared Dirty, Unique Clean and Unique Dirty. Local traffic arrives on a request port: a read that starts a line fill when the line is absent, a make-unique request that gains write permission, and a write that stores data into a line already held uniquely. Fill data comes back on a separate return port.

On the other side, the block serves coherence snoops from the interconnect. A snoop request channel carries a line index and a 4-bit snoop type. The block answers each accepted snoop with a 5-bit response and, when the response says so, one beat of line data. All three snoop channels use valid/ready handshakes. A dirty line that is read by a sharing snoop keeps its dirty attribute and becomes Shared Dirty instead of writing back first. A line that is being filled cannot be snooped until its fill arrives. If a snoop and a local request reach the same line in the same cycle, the snoop goes first.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset, every line reads Invalid on `lk_state` (bit 2 = valid, bit 1 = unique, bit 0 = dirty: Invalid 000, Shared Clean 100, Shared Dirty 101, Unique Clean 110, Unique Dirty 111), `fill_busy`, `cr_valid` and `cd_valid` are low, and `ac_ready` is high.
- R2: A local read (op 0) to an Invalid line raises `fill_busy` and blocks further local requests. The fill return then stores its data and leaves the line Shared Clean when `fill_shared` is 1 and Unique Clean when it is 0. A local read to a valid line changes nothing.
- R3: A make-unique request (op 1) turns Shared Clean into Unique Clean and Shared Dirty into Unique Dirty. It has no effect on any other state.
- R4: A write (op 2) to a Unique Clean or Unique Dirty line stores the data and leaves the line Unique Dirty. A write to any other line leaves both its state and its data unchanged.
- R5: A read-shared snoop (type 4'h1) to a valid line answers with DataTransfer and IsShared set, PassDirty clear and WasUnique equal to the former unique bit. It returns the line data and clears the unique bit while keeping the dirty bit (Unique Dirty becomes Shared Dirty). Response bits are: 0 DataTransfer, 1 Error, 2 PassDirty, 3 IsShared, 4 WasUnique.
- R6: A read-unique snoop (type 4'h7) to a valid line answers with DataTransfer, PassDirty equal to the former dirty bit and WasUnique equal to the former unique bit. It returns the data and leaves the line Invalid.
- R7: An invalidating snoop (type 4'hD) to a valid line answers with only WasUnique (the former unique bit), returns no data and leaves the line Invalid.
- R8: A snoop of type 4'h1, 4'h7 or 4'hD to an Invalid line answers with all response bits zero and returns no data.
- R9: A snoop of any other type answers with only the Error bit set, returns no data and leaves the line unchanged.
- R10: The response appears one cycle after the snoop is accepted and stays stable until `cr_ready`. A data beat, with `cd_last` high, follows only when DataTransfer is set and stays until `cd_ready`. No new snoop is accepted while a response or beat is outstanding.
- R11: While a fill is pending, a snoop to the line being filled is held off with `ac_ready` low until the fill returns.
- R12: When a snoop is accepted in the same cycle that a local request targets the same line, `lreq_ready` is low and the snoop's state change is applied first. The local request completes on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_ready | output | 1 | Local request accepted this cycle |
| lreq_op | input | 2 | 0 read, 1 make-unique, 2 write, 3 none |
| lreq_idx | input | IDX_W | Line index of the local request |
| lreq_data | input | DATA_W | Write data |
| fill_busy | output | 1 | A line fill is outstanding |
| fill_valid | input | 1 | Fill data returned |
| fill_shared | input | 1 | Other caches also hold the filled line |
| fill_data | input | DATA_W | Fill data |
| lk_idx | input | IDX_W | Lookup index |
| lk_state | output | 3 | State of the looked-up line |
| lk_data | output | DATA_W | Data of the looked-up line |
| ac_valid | input | 1 | Snoop request valid |
| ac_ready | output | 1 | Snoop request accepted |
| ac_addr | input | IDX_W | Line index of the snoop |
| ac_snoop | input | 4 | Snoop type |
| cr_valid | output | 1 | Snoop response valid |
| cr_ready | input | 1 | Snoop response taken |
| cr_resp | output | 5 | Snoop response bits |
| cd_valid | output | 1 | Snoop data beat valid |
| cd_ready | input | 1 | Snoop data beat taken |
| cd_data | output | DATA_W | Snoop data |
| cd_last | output | 1 | Last beat of snoop data |

## Verification
The assertions assume that `fill_valid` is raised only while `fill_busy` is high. They also assume that local requests and snoops use line indices below the configured line count. They make no assumption that a snoop request stays valid until it is accepted. The bench follows these rules: it issues a fill return only after its own model has seen a fill start, and it draws indices only from the line range. It draws random local operations, snoop types (including an undefined type) and response and data back-pressure delays. Directed sequences cover the fill stall and the same-line collision.

// File: rtl/coh_pkg.sv
package coh_pkg;

  // state bits: [2] valid, [1] unique, [0] dirty
  typedef enum logic [2:0] {
    ST_I  = 3'b000,
    ST_SC = 3'b100,
    ST_SD = 3'b101,
    ST_UC = 3'b110,
    ST_UD = 3'b111
  } line_st_e;

  typedef enum logic [1:0] {
    LOP_READ  = 2'd0,
    LOP_UNIQ  = 2'd1,
    LOP_WRITE = 2'd2,
    LOP_NONE  = 2'd3
  } lop_e;

  localparam logic [3:0] SNP_RD_SHARED = 4'h1;
  localparam logic [3:0] SNP_RD_UNIQUE = 4'h7;
  localparam logic [3:0] SNP_MAKE_INV  = 4'hD;

  localparam int RSP_DT  = 0;
  localparam int RSP_ERR = 1;
  localparam int RSP_PD  = 2;
  localparam int RSP_IS  = 3;
  localparam int RSP_WU  = 4;

  function automatic logic [4:0] snp_resp(line_st_e s, logic [3:0] t);
    logic [4:0] r;
    r = '0;
    case (t)
      SNP_RD_SHARED: if (s[2]) begin
        r[RSP_DT] = 1'b1;
        r[RSP_IS] = 1'b1;
        r[RSP_WU] = s[1];
      end
      SNP_RD_UNIQUE: if (s[2]) begin
        r[RSP_DT] = 1'b1;
        r[RSP_PD] = s[0];
        r[RSP_WU] = s[1];
      end
      SNP_MAKE_INV: if (s[2]) r[RSP_WU] = s[1];
      default: r[RSP_ERR] = 1'b1;
    endcase
    return r;
  endfunction

  function automatic line_st_e snp_next(line_st_e s, logic [3:0] t);
    line_st_e n;
    n = s;
    case (t)
      SNP_RD_SHARED: if (s[2]) n = line_st_e'({2'b10, s[0]});
      SNP_RD_UNIQUE, SNP_MAKE_INV: n = ST_I;
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_we,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          snp_st,
  input  logic              loc_we,
  input  logic              loc_dwe,
  input  logic [IDX_W-1:0]  loc_idx,
  input  line_st_e          loc_st,
  input  logic [DATA_W-1:0] loc_data,
  output line_st_e          line_st   [NLINES],
  output logic [DATA_W-1:0] line_data [NLINES]
);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_st_e          st_q;
    logic [DATA_W-1:0] dat_q;
    logic              snp_hit, loc_hit, dat_en;

    assign snp_hit = snp_we  && (snp_idx == IDX_W'(g));
    assign loc_hit = loc_we  && (loc_idx == IDX_W'(g));
    assign dat_en  = loc_dwe && (loc_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= ST_I;
      else if (snp_hit) st_q <= snp_st;
      else if (loc_hit) st_q <= loc_st;
    end

    always_ff @(posedge clk) begin
      if (dat_en) dat_q <= loc_data;
    end

    assign line_st[g]   = st_q;
    assign line_data[g] = dat_q;
  end

  // R12: snoop update and local update never land on one line together
  a_r12_ports_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_we && loc_we) |-> (snp_idx != loc_idx));

  // R4: data only enters a held line if that line is held uniquely
  a_r4_write_needs_unique: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_dwe && line_st[loc_idx][2]) |-> line_st[loc_idx][1]);

endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
  import coh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ac_valid,
  input  logic [3:0]        ac_snoop,
  input  logic              blocked,
  output logic              ac_ready,
  input  line_st_e          cur_st,
  input  logic [DATA_W-1:0] cur_data,
  output logic              upd_we,
  output line_st_e          upd_st,
  output logic              cr_valid,
  input  logic              cr_ready,
  output logic [4:0]        cr_resp,
  output logic              cd_valid,
  input  logic              cd_ready,
  output logic [DATA_W-1:0] cd_data,
  output logic              cd_last
);

  typedef enum logic [1:0] {SP_IDLE, SP_RESP, SP_DATA} sp_e;

  sp_e               sp_q, sp_d;
  logic [4:0]        resp_q, resp_d;
  logic [DATA_W-1:0] data_q;

  assign ac_ready = (sp_q == SP_IDLE) && !blocked;
  assign upd_we   = ac_valid && ac_ready;
  assign upd_st   = snp_next(cur_st, ac_snoop);

  always_comb begin
    sp_d   = sp_q;
    resp_d = resp_q;
    case (sp_q)
      SP_IDLE: if (upd_we) begin
        sp_d   = SP_RESP;
        resp_d = snp_resp(cur_st, ac_snoop);
      end
      SP_RESP: if (cr_ready) sp_d = resp_q[RSP_DT] ? SP_DATA : SP_IDLE;
      SP_DATA: if (cd_ready) sp_d = SP_IDLE;
      default: sp_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_IDLE;
      resp_q <= '0;
    end else begin
      sp_q   <= sp_d;
      resp_q <= resp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_we) data_q <= cur_data;
  end

  assign cr_valid = (sp_q == SP_RESP);
  assign cr_resp  = resp_q;
  assign cd_valid = (sp_q == SP_DATA);
  assign cd_data  = data_q;
  assign cd_last  = cd_valid;

  // R10: response holds steady until taken
  a_r10_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && !cr_ready) |=> (cr_valid && $stable(cr_resp)));

  // R10: data beat holds until taken
  a_r10_cd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_valid && !cd_ready) |=> (cd_valid && $stable(cd_data)));

  // R10: a data beat only follows a taken response that announced data
  a_r10_cd_after_dt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_valid) |-> ($past(cr_valid && cr_ready) && cr_resp[RSP_DT]));

  // R10: nothing new accepted while a snoop is in flight
  a_r10_one_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid || cd_valid) |-> !ac_ready);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  output logic              lreq_ready,
  input  logic [1:0]        lreq_op,
  input  logic [IDX_W-1:0]  lreq_idx,
  input  logic [DATA_W-1:0] lreq_data,
  output logic              fill_busy,
  input  logic              fill_valid,
  input  logic              fill_shared,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [2:0]        lk_state,
  output logic [DATA_W-1:0] lk_data,
  input  logic              ac_valid,
  output logic              ac_ready,
  input  logic [IDX_W-1:0]  ac_addr,
  input  logic [3:0]        ac_snoop,
  output logic              cr_valid,
  input  logic              cr_ready,
  output logic [4:0]        cr_resp,
  output logic              cd_valid,
  input  logic              cd_ready,
  output logic [DATA_W-1:0] cd_data,
  output logic              cd_last
);

  line_st_e          line_st   [NLINES];
  logic [DATA_W-1:0] line_data [NLINES];

  logic              fill_q, fill_d;
  logic [IDX_W-1:0]  fill_idx_q, fill_idx_d;
  logic              blocked, ac_fire, lreq_fire;
  logic              snp_we;
  line_st_e          snp_st;
  logic              loc_we, loc_dwe;
  logic [IDX_W-1:0]  loc_idx;
  line_st_e          loc_st, cur_l;
  logic [DATA_W-1:0] loc_data;

  assign blocked    = fill_q && (ac_addr == fill_idx_q);
  assign ac_fire    = ac_valid && ac_ready;
  assign lreq_ready = !fill_q && !(ac_fire && (ac_addr == lreq_idx));
  assign lreq_fire  = lreq_valid && lreq_ready;
  assign cur_l      = line_st[lreq_idx];

  coh_snoop_ctl #(.DATA_W(DATA_W)) i_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .ac_valid (ac_valid),
    .ac_snoop (ac_snoop),
    .blocked  (blocked),
    .ac_ready (ac_ready),
    .cur_st   (line_st[ac_addr]),
    .cur_data (line_data[ac_addr]),
    .upd_we   (snp_we),
    .upd_st   (snp_st),
    .cr_valid (cr_valid),
    .cr_ready (cr_ready),
    .cr_resp  (cr_resp),
    .cd_valid (cd_valid),
    .cd_ready (cd_ready),
    .cd_data  (cd_data),
    .cd_last  (cd_last)
  );

  always_comb begin
    loc_we     = 1'b0;
    loc_dwe    = 1'b0;
    loc_idx    = lreq_idx;
    loc_st     = cur_l;
    loc_data   = lreq_data;
    fill_d     = fill_q;
    fill_idx_d = fill_idx_q;
    if (fill_q && fill_valid) begin
      loc_we   = 1'b1;
      loc_dwe  = 1'b1;
      loc_idx  = fill_idx_q;
      loc_st   = fill_shared ? ST_SC : ST_UC;
      loc_data = fill_data;
      fill_d   = 1'b0;
    end else if (lreq_fire) begin
      case (lop_e'(lreq_op))
        LOP_READ: if (!cur_l[2]) begin
          fill_d     = 1'b1;
          fill_idx_d = lreq_idx;
        end
        LOP_UNIQ: if (cur_l[2] && !cur_l[1]) begin
          loc_we = 1'b1;
          loc_st = line_st_e'({2'b11, cur_l[0]});
        end
        LOP_WRITE: if (cur_l[1]) begin
          loc_we  = 1'b1;
          loc_dwe = 1'b1;
          loc_st  = ST_UD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= 1'b0;
      fill_idx_q <= '0;
    end else begin
      fill_q <= fill_d;
      if (fill_d && !fill_q) fill_idx_q <= fill_idx_d;
    end
  end

  coh_line_array #(.NLINES(NLINES), .DATA_W(DATA_W)) i_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_we    (snp_we),
    .snp_idx   (ac_addr),
    .snp_st    (snp_st),
    .loc_we    (loc_we),
    .loc_dwe   (loc_dwe),
    .loc_idx   (loc_idx),
    .loc_st    (loc_st),
    .loc_data  (loc_data),
    .line_st   (line_st),
    .line_data (line_data)
  );

  assign fill_busy = fill_q;
  assign lk_state  = line_st[lk_idx];
  assign lk_data   = line_data[lk_idx];

  // R11: no snoop enters the line whose fill is outstanding
  a_r11_fill_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q && ac_valid && (ac_addr == fill_idx_q)) |-> !ac_ready);

  // R2: a returned fill closes the outstanding fill
  a_r2_fill_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q && fill_valid) |=> !fill_busy);

  // R2: local requests wait while a fill is outstanding
  a_r2_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !lreq_ready);

endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  localparam int NL = 4;
  localparam int DW = 32;

  logic clk, rst_n;
  logic lreq_valid, lreq_ready;
  logic [1:0] lreq_op;
  logic [1:0] lreq_idx;
  logic [DW-1:0] lreq_data;
  logic fill_busy, fill_valid, fill_shared;
  logic [DW-1:0] fill_data;
  logic [1:0] lk_idx;
  logic [2:0] lk_state;
  logic [DW-1:0] lk_data;
  logic ac_valid, ac_ready;
  logic [1:0] ac_addr;
  logic [3:0] ac_snoop;
  logic cr_valid, cr_ready;
  logic [4:0] cr_resp;
  logic cd_valid, cd_ready, cd_last;
  logic [DW-1:0] cd_data;

  coh_line_ctrl #(.NLINES(NL), .DATA_W(DW)) i_coh_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_op(lreq_op),
    .lreq_idx(lreq_idx), .lreq_data(lreq_data),
    .fill_busy(fill_busy), .fill_valid(fill_valid), .fill_shared(fill_shared),
    .fill_data(fill_data),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_data(lk_data),
    .ac_valid(ac_valid), .ac_ready(ac_ready), .ac_addr(ac_addr), .ac_snoop(ac_snoop),
    .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_resp(cr_resp),
    .cd_valid(cd_valid), .cd_ready(cd_ready), .cd_data(cd_data), .cd_last(cd_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [2:0]    m_st  [NL];
  logic [DW-1:0] m_dat [NL];
  bit            m_fill;
  int            m_fidx;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // expected snoop answer from the requirements
  function automatic logic [4:0] e_resp(logic [2:0] s, logic [3:0] t);
    logic [4:0] r = 5'b0;
    if (t == 4'h1 || t == 4'h7 || t == 4'hD) begin
      if (s[2]) begin
        r[4] = s[1];
        if (t == 4'h1) begin r[0] = 1'b1; r[3] = 1'b1; end
        if (t == 4'h7) begin r[0] = 1'b1; r[2] = s[0]; end
      end
    end else r[1] = 1'b1;
    return r;
  endfunction

  function automatic logic [2:0] e_next(logic [2:0] s, logic [3:0] t);
    if (t == 4'h1) return s[2] ? {2'b10, s[0]} : s;
    if (t == 4'h7 || t == 4'hD) return 3'b000;
    return s;
  endfunction

  function automatic string snp_tag(logic [2:0] s, logic [3:0] t);
    if (!(t == 4'h1 || t == 4'h7 || t == 4'hD)) return "R9";
    if (!s[2]) return "R8";
    if (t == 4'h1) return "R5";
    if (t == 4'h7) return "R6";
    return "R7";
  endfunction

  task automatic check_line(input int idx, input string tag);
    lk_idx = idx[1:0];
    #1;
    chk(lk_state == m_st[idx], tag, lk_state, m_st[idx]);
    if (m_st[idx][2]) chk(lk_data == m_dat[idx], tag, lk_data, m_dat[idx]);
  endtask

  task automatic local_op(input int op, input int idx, input logic [DW-1:0] d);
    string tag;
    tag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
    @(negedge clk);
    lreq_valid = 1; lreq_op = op[1:0]; lreq_idx = idx[1:0]; lreq_data = d;
    #1 chk(lreq_ready == 1'b1, tag, lreq_ready, 1);
    @(posedge clk);
    @(negedge clk);
    lreq_valid = 0;
    case (op)
      0: if (!m_st[idx][2]) begin m_fill = 1; m_fidx = idx; end
      1: if (m_st[idx][2] && !m_st[idx][1]) m_st[idx] = {2'b11, m_st[idx][0]};
      2: if (m_st[idx][1]) begin m_st[idx] = 3'b111; m_dat[idx] = d; end
      default: ;
    endcase
    chk(fill_busy == m_fill, "R2", fill_busy, m_fill);
    check_line(idx, tag);
  endtask

  task automatic do_fill(input bit sh, input logic [DW-1:0] d);
    @(negedge clk);
    fill_valid = 1; fill_shared = sh; fill_data = d;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
    m_fill = 0;
    m_st[m_fidx] = sh ? 3'b100 : 3'b110;
    m_dat[m_fidx] = d;
    chk(fill_busy == 1'b0, "R2", fill_busy, 0);
    check_line(m_fidx, "R2");
  endtask

  task automatic snoop(input logic [3:0] t, input int idx, input int crd, input int cdd);
    logic [4:0] er;
    logic [DW-1:0] ed;
    string tag;
    er  = e_resp(m_st[idx], t);
    ed  = m_dat[idx];
    tag = snp_tag(m_st[idx], t);
    @(negedge clk);
    ac_valid = 1; ac_addr = idx[1:0]; ac_snoop = t; cr_ready = 0; cd_ready = 0;
    #1 chk(ac_ready == 1'b1, "R10", ac_ready, 1);
    @(posedge clk);
    @(negedge clk);
    ac_valid = 0;
    chk(cr_valid == 1'b1, "R10", cr_valid, 1);
    chk(cr_resp == er, tag, cr_resp, er);
    chk(ac_ready == 1'b0, "R10", ac_ready, 0);
    for (int k = 0; k < crd; k++) begin
      @(posedge clk); @(negedge clk);
      chk(cr_valid && cr_resp == er, "R10", cr_resp, er);
    end
    cr_ready = 1;
    @(posedge clk);
    @(negedge clk);
    cr_ready = 0;
    if (er[0]) begin
      chk(cd_valid && cd_last, tag, {cd_valid, cd_last}, 2'b11);
      chk(cd_data == ed, tag, cd_data, ed);
      for (int k = 0; k < cdd; k++) begin
        @(posedge clk); @(negedge clk);
        chk(cd_valid && cd_data == ed, "R10", cd_data, ed);
      end
      cd_ready = 1;
      @(posedge clk);
      @(negedge clk);
      cd_ready = 0;
    end
    chk(cd_valid == 1'b0, tag, cd_valid, 0);
    chk(ac_ready == 1'b1, "R10", ac_ready, 1);
    m_st[idx] = e_next(m_st[idx], t);
    check_line(idx, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] types [4];
    types[0] = 4'h1; types[1] = 4'h7; types[2] = 4'hD; types[3] = 4'h3;
    void'($urandom(32'd20240611));
    rst_n = 0; lreq_valid = 0; lreq_op = 2'd3; lreq_idx = 0; lreq_data = 0;
    fill_valid = 0; fill_shared = 0; fill_data = 0; lk_idx = 0;
    ac_valid = 0; ac_addr = 0; ac_snoop = 0; cr_ready = 0; cd_ready = 0;
    for (int i = 0; i < NL; i++) begin m_st[i] = 3'b000; m_dat[i] = '0; end
    m_fill = 0; m_fidx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(!fill_busy && !cr_valid && !cd_valid, "R1", {fill_busy, cr_valid, cd_valid}, 0);
    chk(ac_ready == 1'b1, "R1", ac_ready, 1);
    for (int i = 0; i < NL; i++) check_line(i, "R1");

    // directed flow: fill shared, gain uniqueness, write, shared snoop
    local_op(0, 0, '0);
    do_fill(1, 32'h0000_1234);          // R2 -> SC
    local_op(0, 0, '0);                 // R2 read hit: no change
    local_op(1, 0, '0);                 // R3 SC -> UC
    local_op(2, 0, 32'hABCD_0000);      // R4 UC -> UD
    snoop(4'h1, 0, 2, 1);               // R5 UD -> SD, resp 5'b11001
    local_op(2, 0, 32'hDEAD_BEEF);      // R4 ignored on SD
    snoop(4'h3, 0, 0, 0);               // R9 error only
    local_op(1, 0, '0);                 // R3 SD -> UD
    snoop(4'h7, 0, 1, 2);               // R6 PassDirty, -> I
    snoop(4'h1, 0, 0, 0);               // R8 invalid line
    local_op(1, 0, '0);                 // R3 no effect on I
    local_op(0, 3, '0);
    do_fill(0, 32'h5555_AAAA);          // R2 -> UC
    snoop(4'hD, 3, 0, 0);               // R7 -> I, WasUnique

    // R11: snoop held off while its line fills
    local_op(0, 2, '0);
    @(negedge clk);
    ac_valid = 1; ac_addr = 2'd2; ac_snoop = 4'h1; cr_ready = 0;
    fill_valid = 1; fill_shared = 0; fill_data = 32'h0F0F_0F0F;
    #1 chk(ac_ready == 1'b0, "R11", ac_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ac_valid = 0; fill_valid = 0;
    chk(cr_valid == 1'b0, "R11", cr_valid, 0);
    m_fill = 0; m_st[2] = 3'b110; m_dat[2] = 32'h0F0F_0F0F;
    check_line(2, "R11");
    snoop(4'h1, 2, 0, 0);               // now accepted: UC -> SC

    // R12: snoop and local request on one line in one cycle
    @(negedge clk);
    ac_valid = 1; ac_addr = 2'd2; ac_snoop = 4'h7; cr_ready = 0; cd_ready = 0;
    lreq_valid = 1; lreq_op = 2'd1; lreq_idx = 2'd2;
    #1 chk(lreq_ready == 1'b0, "R12", lreq_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ac_valid = 0;
    chk(cr_resp == 5'b00001, "R12", cr_resp, 5'b00001);
    m_st[2] = 3'b000;
    lk_idx = 2'd2;
    #1 chk(lk_state == 3'b000, "R12", lk_state, 0);
    cr_ready = 1; cd_ready = 1;
    @(posedge clk);                     // local retry accepted here (no effect on I)
    @(negedge clk);
    cr_ready = 0;
    lreq_valid = 0;
    chk(cd_valid == 1'b1 && cd_data == m_dat[2], "R12", cd_data, m_dat[2]);
    @(posedge clk);
    @(negedge clk);
    cd_ready = 0;
    check_line(2, "R12");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r, idx;
      r = $urandom % 8;
      idx = $urandom % NL;
      if (r < 4) begin
        local_op(r % 3, idx, $urandom);
        if (m_fill) do_fill(1'($urandom % 2), $urandom);
      end else begin
        snoop(types[$urandom % 4], idx, $urandom % 3, $urandom % 3);
      end
    end
    finish_run();
  end
endmodule